// File: doc/BRIEF.md
# Serial Byte Transceiver with Internal Listening Loop

This block sends and receives 8-bit asynchronous serial characters with one start bit, one stop bit and an optional parity bit. A 2-bit mode word picks the frame: no parity, even parity or odd parity. A fourth code selects listening mode. In that mode the frame has no parity, the transmitted bit stream goes straight into the receiver, and the transmit pin is held at the idle level.

Bytes enter through a valid/ready handshake. Received bytes leave as a one-cycle strobe that carries a parity-error flag and a framing-error flag. All bit timing comes from an external enable tick running at sixteen times the bit rate. A single busy output is high while either direction is working on a frame.

Top module: `uart_listen_core`

## Requirements
- R1: After reset `txd_o` is 1, `tx_ready_o` is 1, `busy_o` is 0 and `rx_valid_o` is 0.
- R2: A transmitted frame is a start bit (0), then the 8 data bits with bit 0 first, then a stop bit (1). Each bit lasts 16 ticks of `tick_en`. Modes 2'b00 and 2'b11 insert no parity bit. The line is 1 whenever the transmitter is idle.
- R3: In mode 2'b01 a parity bit follows data bit 7. Its value makes the count of ones over the data bits and the parity bit even.
- R4: In mode 2'b10 a parity bit follows data bit 7. Its value makes the count of ones over the data bits and the parity bit odd.
- R5: `tx_ready_o` is 1 only while the transmitter is idle. A byte is taken on a clock edge where `tx_valid_i` and `tx_ready_o` are both 1. `tx_ready_o` is 0 from the next cycle and returns to 1 once the stop bit has been sent in full.
- R6: The receiver confirms a start bit by sampling it at half a bit time. It then samples every later bit at its centre. It outputs the byte on `rx_data_o` with a one-cycle `rx_valid_o` pulse at the centre of the stop bit. A low pulse shorter than half a bit produces no byte.
- R7: In modes 2'b01 and 2'b10, `rx_parity_err_o` is 1 with the byte when the received parity bit breaks the selected rule. In modes 2'b00 and 2'b11 it is always 0.
- R8: `rx_frame_err_o` is 1 with the byte when the stop bit samples 0. After such a frame the receiver waits for the line to return to 1 before it looks for the next start bit.
- R9: In mode 2'b11, `txd_o` is held at 1, the transmitter's own bit stream is received, and the level on `rxd_i` has no effect.
- R10: `busy_o` is 1 while a frame is being sent or received, and 0 when both directions are idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_en | input | 1 | Oversampling enable, 16 per bit time |
| mode_i | input | 2 | Frame and listening mode select |
| tx_valid_i | input | 1 | Transmit byte offered |
| tx_data_i | input | 8 | Transmit byte |
| tx_ready_o | output | 1 | Transmitter can take a byte |
| txd_o | output | 1 | Serial transmit pin |
| rxd_i | input | 1 | Serial receive pin |
| rx_valid_o | output | 1 | One-cycle strobe for a received byte |
| rx_data_o | output | 8 | Received byte |
| rx_parity_err_o | output | 1 | Parity mismatch on the received byte |
| rx_frame_err_o | output | 1 | Stop bit of the received byte was 0 |
| busy_o | output | 1 | A frame is in progress in either direction |

## Verification
The bench runs a model of the transmit line clock by clock. It catches a frame that sends bits MSB first, has a wrong bit length, drops or inverts the parity bit, or lets the pin move in listening mode. The bench holds `rxd_i` low during listening mode; a design that still reads the pin would report phantom bytes. Injected frames with a bad parity bit and a low stop bit check the error flags. The stop-low frame also shows whether a receiver that re-arms at once then decodes a false byte from the held-low line. A short low glitch shows whether the start bit is really confirmed at mid-bit and not on its edge.

// File: rtl/uart_lsn_pkg.sv
package uart_lsn_pkg;

   localparam logic [1:0] MODE_PLAIN  = 2'b00;
   localparam logic [1:0] MODE_EVEN   = 2'b01;
   localparam logic [1:0] MODE_ODD    = 2'b10;
   localparam logic [1:0] MODE_LISTEN = 2'b11;

   typedef enum logic [2:0] {
      FS_IDLE,
      FS_START,
      FS_DATA,
      FS_PAR,
      FS_STOP,
      FS_WAITHI
   } frm_state_e;

   function automatic logic mode_has_parity(input logic [1:0] mode);
      return (mode == MODE_EVEN) || (mode == MODE_ODD);
   endfunction

   function automatic logic mode_is_odd(input logic [1:0] mode);
      return mode == MODE_ODD;
   endfunction

endpackage

// File: rtl/uart_lsn_sync.sv
module uart_lsn_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic q_o
);
   generate
      if (STAGES == 0) begin : g_bypass
         assign q_o = d_i;
      end else begin : g_chain
         logic [STAGES-1:0] chain_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= '1;
            else        chain_q <= {chain_q[STAGES-2:0], d_i} ;
         end
         assign q_o = chain_q[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/uart_lsn_tx.sv
module uart_lsn_tx
   import uart_lsn_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int OVS    = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_en,
   input  logic [1:0]        mode_i,
   input  logic              valid_i,
   input  logic [DATA_W-1:0] data_i,
   output logic              ready_o,
   output logic              line_o,
   output logic              active_o
);
   localparam int CNT_W = $clog2(OVS);
   localparam int IDX_W = $clog2(DATA_W);
   localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(OVS - 1);
   localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(DATA_W - 1);

   frm_state_e        state_q;
   logic [CNT_W-1:0]  cnt_q;
   logic [IDX_W-1:0]  idx_q;
   logic [DATA_W-1:0] shreg_q;
   logic              par_q;
   logic              par_en_q;
   logic              line_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= FS_IDLE;
         cnt_q    <= '0;
         idx_q    <= '0;
         shreg_q  <= '0;
         par_q    <= 1'b0;
         par_en_q <= 1'b0;
         line_q   <= 1'b1;
      end else if (state_q == FS_IDLE) begin
         cnt_q <= '0;
         idx_q <= '0;
         if (valid_i) begin
            shreg_q  <= data_i;
            par_en_q <= mode_has_parity(mode_i);
            par_q    <= (^data_i) ^ mode_is_odd(mode_i);
            line_q   <= 1'b0;
            state_q  <= FS_START;
         end
      end else if (tick_en) begin
         if (cnt_q != CNT_LAST) begin
            cnt_q <= cnt_q + 1'b1;
         end else begin
            cnt_q <= '0;
            unique case (state_q)
               FS_START: begin
                  state_q <= FS_DATA;
                  line_q  <= shreg_q[0];
               end
               FS_DATA: begin
                  if (idx_q == IDX_LAST) begin
                     state_q <= par_en_q ? FS_PAR : FS_STOP;
                     line_q  <= par_en_q ? par_q : 1'b1;
                  end else begin
                     idx_q   <= idx_q + 1'b1;
                     shreg_q <= shreg_q >> 1;
                     line_q  <= shreg_q[1];
                  end
               end
               FS_PAR: begin
                  state_q <= FS_STOP;
                  line_q  <= 1'b1;
               end
               default: begin
                  state_q <= FS_IDLE;
                  line_q  <= 1'b1;
               end
            endcase
         end
      end
   end

   assign ready_o  = (state_q == FS_IDLE);
   assign active_o = (state_q != FS_IDLE);
   assign line_o   = line_q;
endmodule

// File: rtl/uart_lsn_rx.sv
module uart_lsn_rx
   import uart_lsn_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int OVS    = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_en,
   input  logic [1:0]        mode_i,
   input  logic              line_i,
   output logic              valid_o,
   output logic [DATA_W-1:0] data_o,
   output logic              perr_o,
   output logic              ferr_o,
   output logic              active_o
);
   localparam int CNT_W = $clog2(OVS);
   localparam int IDX_W = $clog2(DATA_W);
   localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(OVS - 1);
   localparam logic [CNT_W-1:0] CNT_HALF = CNT_W'(OVS / 2 - 1);
   localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(DATA_W - 1);

   frm_state_e        state_q;
   logic [CNT_W-1:0]  cnt_q;
   logic [IDX_W-1:0]  idx_q;
   logic [DATA_W-1:0] shreg_q;
   logic              par_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= FS_IDLE;
         cnt_q   <= '0;
         idx_q   <= '0;
         shreg_q <= '0;
         par_q   <= 1'b0;
         valid_o <= 1'b0;
         data_o  <= '0;
         perr_o  <= 1'b0;
         ferr_o  <= 1'b0;
      end else begin
         valid_o <= 1'b0;
         unique case (state_q)
            FS_IDLE: begin
               cnt_q <= '0;
               idx_q <= '0;
               if (tick_en && !line_i) state_q <= FS_START;
            end
            FS_START: if (tick_en) begin
               if (cnt_q == CNT_HALF) begin
                  cnt_q   <= '0;
                  state_q <= line_i ? FS_IDLE : FS_DATA;
               end else begin
                  cnt_q <= cnt_q + 1'b1;
               end
            end
            FS_DATA: if (tick_en) begin
               if (cnt_q == CNT_LAST) begin
                  cnt_q   <= '0;
                  shreg_q <= {line_i, shreg_q[DATA_W-1:1]};
                  if (idx_q == IDX_LAST)
                     state_q <= mode_has_parity(mode_i) ? FS_PAR : FS_STOP;
                  else
                     idx_q <= idx_q + 1'b1;
               end else begin
                  cnt_q <= cnt_q + 1'b1;
               end
            end
            FS_PAR: if (tick_en) begin
               if (cnt_q == CNT_LAST) begin
                  cnt_q   <= '0;
                  par_q   <= line_i;
                  state_q <= FS_STOP;
               end else begin
                  cnt_q <= cnt_q + 1'b1;
               end
            end
            FS_STOP: if (tick_en) begin
               if (cnt_q == CNT_LAST) begin
                  cnt_q   <= '0;
                  valid_o <= 1'b1;
                  data_o  <= shreg_q;
                  ferr_o  <= !line_i;
                  perr_o  <= mode_has_parity(mode_i) &&
                             (par_q != ((^shreg_q) ^ mode_is_odd(mode_i)));
                  state_q <= line_i ? FS_IDLE : FS_WAITHI;
               end else begin
                  cnt_q <= cnt_q + 1'b1;
               end
            end
            default: if (line_i) state_q <= FS_IDLE;
         endcase
      end
   end

   assign active_o = (state_q != FS_IDLE);
endmodule

// File: rtl/uart_listen_core.sv
module uart_listen_core
   import uart_lsn_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int OVS         = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_en,
   input  logic [1:0]        mode_i,
   input  logic              tx_valid_i,
   input  logic [DATA_W-1:0] tx_data_i,
   output logic              tx_ready_o,
   output logic              txd_o,
   input  logic              rxd_i,
   output logic              rx_valid_o,
   output logic [DATA_W-1:0] rx_data_o,
   output logic              rx_parity_err_o,
   output logic              rx_frame_err_o,
   output logic              busy_o
);
   generate
      if (OVS < 4 || (OVS % 2) != 0) begin : g_bad_ovs
         $error("uart_listen_core: OVS must be even and at least 4");
      end
      if (DATA_W < 2) begin : g_bad_width
         $error("uart_listen_core: DATA_W must be at least 2");
      end
      if (SYNC_STAGES < 0 || SYNC_STAGES == 1 || SYNC_STAGES > 4) begin : g_bad_sync
         $error("uart_listen_core: SYNC_STAGES must be 0, 2, 3 or 4");
      end
   endgenerate

   logic listen;
   logic tx_line;
   logic tx_active;
   logic rx_active;
   logic rx_src;
   logic rx_line;

   assign listen = (mode_i == MODE_LISTEN);

   uart_lsn_tx #(.DATA_W(DATA_W), .OVS(OVS)) u_tx (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick_en  (tick_en),
      .mode_i   (mode_i),
      .valid_i  (tx_valid_i),
      .data_i   (tx_data_i),
      .ready_o  (tx_ready_o),
      .line_o   (tx_line),
      .active_o (tx_active)
   );

   assign rx_src = listen ? tx_line : rxd_i;
   assign txd_o  = listen ? 1'b1 : tx_line;

   uart_lsn_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (rx_src),
      .q_o   (rx_line)
   );

   uart_lsn_rx #(.DATA_W(DATA_W), .OVS(OVS)) u_rx (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick_en  (tick_en),
      .mode_i   (mode_i),
      .line_i   (rx_line),
      .valid_o  (rx_valid_o),
      .data_o   (rx_data_o),
      .perr_o   (rx_parity_err_o),
      .ferr_o   (rx_frame_err_o),
      .active_o (rx_active)
   );

   assign busy_o = tx_active | rx_active;
endmodule

// File: rtl/uart_listen_core_chk.sv
module uart_listen_core_chk #(
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic [1:0]        mode_i,
   input logic              tx_valid_i,
   input logic              tx_ready_o,
   input logic              txd_o,
   input logic              rx_valid_o,
   input logic [DATA_W-1:0] rx_data_o,
   input logic              rx_parity_err_o,
   input logic              busy_o
);
   assert_idle_line_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
      tx_ready_o |-> txd_o);

   assert_start_bit_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_valid_i && tx_ready_o && mode_i != 2'b11) |=> !txd_o);

   assert_accept_drops_ready_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_valid_i && tx_ready_o) |=> !tx_ready_o);

   assert_single_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid_o |=> !rx_valid_o);

   assert_stable_byte_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !rx_valid_o |-> $stable(rx_data_o));

   assert_no_parity_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_valid_o && (mode_i == 2'b00 || mode_i == 2'b11)) |-> !rx_parity_err_o);

   assert_listen_pin_high_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_i == 2'b11) |-> txd_o);

   assert_busy_while_sending_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !tx_ready_o |-> busy_o);
endmodule

bind uart_listen_core uart_listen_core_chk #(.DATA_W(DATA_W)) u_chk (
   .clk             (clk),
   .rst_n           (rst_n),
   .mode_i          (mode_i),
   .tx_valid_i      (tx_valid_i),
   .tx_ready_o      (tx_ready_o),
   .txd_o           (txd_o),
   .rx_valid_o      (rx_valid_o),
   .rx_data_o       (rx_data_o),
   .rx_parity_err_o (rx_parity_err_o),
   .busy_o          (busy_o)
);

// File: tb/uart_listen_core_tb.sv
module uart_listen_core_tb;
   localparam int CLK_PERIOD = 10;
   localparam int OVS        = 16;
   localparam int TICK_DIV   = 4;
   localparam int BIT_CLKS   = OVS * TICK_DIV;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick_en = 1'b0;
   logic [1:0] mode = 2'b00;
   logic       tx_valid = 1'b0;
   logic [7:0] tx_data = 8'h00;
   logic       tx_ready;
   logic       txd;
   logic       rxd;
   logic       rxd_drv = 1'b1;
   logic       loop_en = 1'b0;
   logic       rx_valid;
   logic [7:0] rx_data;
   logic       rx_perr;
   logic       rx_ferr;
   logic       busy;

   int n_chk  = 0;
   int n_fail = 0;
   int tick_cnt = 0;

   assign rxd = loop_en ? txd : rxd_drv;

   uart_listen_core u_dut (
      .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .mode_i(mode),
      .tx_valid_i(tx_valid), .tx_data_i(tx_data), .tx_ready_o(tx_ready),
      .txd_o(txd), .rxd_i(rxd), .rx_valid_o(rx_valid), .rx_data_o(rx_data),
      .rx_parity_err_o(rx_perr), .rx_frame_err_o(rx_ferr), .busy_o(busy)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   always @(negedge clk) begin
      tick_en  <= (tick_cnt == 0);
      tick_cnt <= (tick_cnt == TICK_DIV - 1) ? 0 : tick_cnt + 1;
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   // behavioural model of the transmit line and expected received bytes
   bit m_busy = 1'b0;
   bit m_cur  = 1'b1;
   int m_left = 0;
   bit m_bits[$];
   int exp_rx[$];

   always @(posedge clk) begin
      if (!rst_n) begin
         m_busy = 1'b0;
         m_cur  = 1'b1;
         m_bits.delete();
      end else if (!m_busy) begin
         if (tx_valid) begin
            m_bits.delete();
            for (int i = 0; i < 8; i++) m_bits.push_back(tx_data[i]);
            if (mode == 2'b01) m_bits.push_back(^tx_data);
            if (mode == 2'b10) m_bits.push_back(~(^tx_data));
            m_bits.push_back(1'b1);
            m_cur  = 1'b0;
            m_left = OVS;
            m_busy = 1'b1;
            if (loop_en || mode == 2'b11) exp_rx.push_back({24'd0, tx_data});
         end
      end else if (tick_en) begin
         m_left--;
         if (m_left == 0) begin
            if (m_bits.size() == 0) begin
               m_busy = 1'b0;
               m_cur  = 1'b1;
            end else begin
               m_cur  = m_bits.pop_front();
               m_left = OVS;
            end
         end
      end
   end

   // compare on every clock, a quarter period after the edge
   always @(posedge clk) begin
      #(CLK_PERIOD/4);
      if (rst_n) begin
         chk(txd === ((mode == 2'b11) ? 1'b1 : m_cur),
             (mode == 2'b11) ? "R9" : "R2", "txd_o", txd, m_cur);
         chk(tx_ready === !m_busy, "R5", "tx_ready_o", tx_ready, !m_busy);
         if (m_busy) chk(busy === 1'b1, "R10", "busy_o while sending", busy, 1);
         if (rx_valid) begin
            if (exp_rx.size() == 0) begin
               chk(1'b0, "R6", "unexpected rx byte", rx_data, 0);
            end else begin
               int e;
               e = exp_rx.pop_front();
               chk(rx_data === e[7:0], "R6", "rx_data_o", rx_data, e[7:0]);
               chk(rx_perr === e[8], "R7", "rx_parity_err_o", rx_perr, e[8]);
               chk(rx_ferr === e[9], "R8", "rx_frame_err_o", rx_ferr, e[9]);
            end
         end
      end
   end

   task automatic send_tx(input logic [7:0] d);
      @(negedge clk);
      while (!tx_ready) @(negedge clk);
      tx_valid = 1'b1;
      tx_data  = d;
      @(negedge clk);
      tx_valid = 1'b0;
      while (!tx_ready) @(negedge clk);
   endtask

   task automatic drive_bit(input bit b);
      rxd_drv = b;
      repeat (BIT_CLKS) @(negedge clk);
   endtask

   task automatic send_ext(input logic [7:0] d, input bit use_par,
                           input bit par_val, input bit stop_val);
      @(negedge clk);
      drive_bit(1'b0);
      for (int i = 0; i < 8; i++) begin
         drive_bit(d[i]);
         if (i == 3) chk(busy === 1'b1, "R10", "busy_o while receiving", busy, 1);
      end
      if (use_par) drive_bit(par_val);
      drive_bit(stop_val);
      rxd_drv = 1'b1;
      repeat (BIT_CLKS) @(negedge clk);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      chk(1'b0, "R10", "watchdog expired", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (4) @(negedge clk);
      chk(txd === 1'b1, "R1", "txd_o in reset", txd, 1);
      chk(tx_ready === 1'b1, "R1", "tx_ready_o in reset", tx_ready, 1);
      chk(busy === 1'b0, "R1", "busy_o in reset", busy, 0);
      chk(rx_valid === 1'b0, "R1", "rx_valid_o in reset", rx_valid, 0);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);
      chk(txd === 1'b1 && tx_ready === 1'b1 && busy === 1'b0, "R1",
          "idle after reset", {txd, tx_ready, busy}, 3'b110);

      // R2: plain frames looped back externally
      loop_en = 1'b1;
      mode = 2'b00;
      send_tx(8'hA5); send_tx(8'h00); send_tx(8'hFF); send_tx(8'h3C);
      // R3: even parity
      mode = 2'b01;
      send_tx(8'h01); send_tx(8'h03);
      // R4: odd parity
      mode = 2'b10;
      send_tx(8'h01); send_tx(8'h00);
      repeat (BIT_CLKS) @(negedge clk);

      // R9: listening mode, external pin held low and ignored
      loop_en = 1'b0;
      mode    = 2'b11;
      rxd_drv = 1'b0;
      repeat (2 * BIT_CLKS) @(negedge clk);
      chk(rx_valid === 1'b0 && exp_rx.size() == 0, "R9", "pin ignored in listen",
          exp_rx.size(), 0);
      send_tx(8'h5A);
      send_tx(8'h81);
      repeat (BIT_CLKS) @(negedge clk);
      chk(exp_rx.size() == 0, "R9", "loopback bytes received", exp_rx.size(), 0);
      chk(busy === 1'b0, "R10", "busy_o idle after listen", busy, 0);
      rxd_drv = 1'b1;
      repeat (BIT_CLKS) @(negedge clk);

      // R8: low stop bit, line then stays low for a while
      mode = 2'b00;
      exp_rx.push_back({22'd0, 1'b1, 1'b0, 8'h96});
      @(negedge clk);
      drive_bit(1'b0);
      for (int i = 0; i < 8; i++) drive_bit(8'h96 >> i);
      drive_bit(1'b0);
      drive_bit(1'b0);
      rxd_drv = 1'b1;
      repeat (2 * BIT_CLKS) @(negedge clk);
      chk(exp_rx.size() == 0, "R8", "framing byte seen once", exp_rx.size(), 0);
      chk(busy === 1'b0, "R8", "receiver re-armed after line high", busy, 0);

      // R7: wrong even parity, then correct odd parity
      mode = 2'b01;
      exp_rx.push_back({22'd0, 1'b0, 1'b1, 8'h07});
      send_ext(8'h07, 1'b1, 1'b0, 1'b1);
      mode = 2'b10;
      exp_rx.push_back({22'd0, 1'b0, 1'b0, 8'h07});
      send_ext(8'h07, 1'b1, 1'b0, 1'b1);
      mode = 2'b00;
      exp_rx.push_back({22'd0, 1'b0, 1'b0, 8'hC3});
      send_ext(8'hC3, 1'b0, 1'b0, 1'b1);

      // R6: short glitch rejected
      @(negedge clk);
      rxd_drv = 1'b0;
      repeat (4 * TICK_DIV) @(negedge clk);
      rxd_drv = 1'b1;
      repeat (12 * BIT_CLKS) @(negedge clk);
      chk(busy === 1'b0, "R6", "glitch leaves receiver idle", busy, 0);
      chk(exp_rx.size() == 0, "R6", "all expected bytes seen", exp_rx.size(), 0);

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule